// File: doc/BRIEF.md
# Predicated Vector Splice Unit

This unit joins two vector operands into one result under a byte-granular predicate. For the chosen element size it looks at the predicate and finds the lowest and the highest active element. The first operand's bytes from the first active element through the end of the last active element form a contiguous segment. Inactive elements that lie between those two are carried along unchanged. The segment is placed at the bottom of the result. The rest of the result, above the segment, is filled from the second operand, starting with that operand's byte 0.

The operation is meant to sit behind a destructive instruction form, where the destination is also the first source. The unit reads both operands as they were on the strobe cycle. A destination that aliases either source therefore never changes the result. The result is registered and appears one cycle after the input strobe, together with a one-cycle valid flag. The vector width in bytes is a parameter. It defaults to 32 and must be a multiple of 8.

Top module: `vsplice_unit`

## Requirements
- R1: The element size code `elem_size` selects 1, 2, 4 or 8 bytes per element for codes 0, 1, 2 and 3. Only predicate bit i with i a multiple of the element size counts as active. Every other predicate bit is ignored.
- R2: Let F and L be the lowest and the highest active byte positions, and E the element size in bytes. The segment length is L − F + E and never exceeds VBYTES. Result byte k, for k below the segment length, equals `vec_a` byte F+k. Byte 0 is bits [7:0] of each vector bus.
- R3: Inactive elements that lie between the first and the last active element are copied into the result unchanged.
- R4: Result byte k, for k from the segment length up to VBYTES−1, equals `vec_b` byte (k − segment length).
- R5: When no predicate bit is active, the result equals `vec_b` in full.
- R6: When every element is active, the result equals `vec_a` in full.
- R7: `out_valid` is high in exactly the cycle after each cycle with `in_valid` high, and low otherwise. Back-to-back strobes give back-to-back results.
- R8: In a cycle without `in_valid`, `out_vec` keeps its previous value.
- R9: After reset, `out_valid` is 0 and `out_vec` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands and predicate are valid this cycle |
| elem_size | input | 2 | Element size code: 0=1, 1=2, 2=4, 3=8 bytes |
| vec_a | input | VBYTES*8 | Operand that supplies the segment |
| vec_b | input | VBYTES*8 | Operand that supplies the back-fill |
| pred | input | VBYTES | Predicate, one bit per byte |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| out_vec | output | VBYTES*8 | Registered splice result |

## Verification
The segment copy and the back-fill always write the same result in the same cycle. They meet at a boundary byte that moves with the predicate and the element size, so a fault in the length arithmetic shows up as a wrong byte on one side of that seam. The bench drives random predicates at all four element sizes, including sparse ones, so the seam lands on many positions. It adds directed patterns that put the seam at byte 0 (nothing active), at the top (all active) and in the middle. Each case also checks misaligned predicate bits that must not move the seam. A second overlap is a new strobe arriving while the previous result is being presented. Back-to-back strobes are judged byte-exact against the bench's own reference function on both consecutive outputs.

// File: rtl/vsplice_pkg.sv
package vsplice_pkg;

   typedef enum logic [1:0] {
      ESZ_B = 2'd0,
      ESZ_H = 2'd1,
      ESZ_W = 2'd2,
      ESZ_D = 2'd3
   } esz_e;

   // bytes per element for an element size code
   function automatic logic [3:0] esz_bytes(esz_e e);
      return 4'd1 << e;
   endfunction

endpackage

// File: rtl/vsplice_span.sv
module vsplice_span
   import vsplice_pkg::*;
#(
   parameter  int VBYTES = 32,
   localparam int IDXW   = $clog2(VBYTES),
   localparam int LENW   = $clog2(VBYTES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [VBYTES-1:0] pred,
   input  esz_e              esz,
   output logic              any_act,
   output logic [IDXW-1:0]   first_pos,
   output logic [LENW-1:0]   seg_len
);

   logic [3:0]        eb;
   logic [2:0]        amask;
   logic [VBYTES-1:0] act;
   logic [IDXW-1:0]   last_pos;

   assign eb    = esz_bytes(esz);
   assign amask = 3'(eb - 4'd1);

   // keep only the predicate bit at the lowest byte of each element
   for (genvar j = 0; j < VBYTES; j++) begin : g_act
      localparam logic [2:0] JLO = 3'(j % 8);
      assign act[j] = pred[j] && ((JLO & amask) == 3'd0);
   end

   always_comb begin
      first_pos = '0;
      for (int k = VBYTES - 1; k >= 0; k--) begin
         if (act[k]) first_pos = IDXW'(k);
      end
   end

   always_comb begin
      last_pos = '0;
      for (int k = 0; k < VBYTES; k++) begin
         if (act[k]) last_pos = IDXW'(k);
      end
   end

   assign any_act = |act;
   assign seg_len = any_act ? (LENW'(last_pos) - LENW'(first_pos) + LENW'(eb)) : '0;

   // R2
   len_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      seg_len <= LENW'(VBYTES));

   // R1
   first_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      any_act |-> pred[first_pos]);

   // R1
   first_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      any_act |-> ((3'(first_pos) & amask) == 3'd0));

   // R2
   order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      any_act |-> (first_pos <= last_pos));

endmodule

// File: rtl/vsplice_shift.sv
module vsplice_shift #(
   parameter  int VBYTES      = 32,
   parameter  bit TOWARD_HIGH = 1'b0,
   localparam int AMTW        = $clog2(VBYTES + 1),
   localparam int W           = VBYTES * 8
) (
   input  logic [W-1:0]    din,
   input  logic [AMTW-1:0] amt,
   output logic [W-1:0]    dout
);

   logic [W-1:0] stg [AMTW+1];

   assign stg[0] = din;

   // logarithmic byte shifter, one stage per amount bit
   for (genvar s = 0; s < AMTW; s++) begin : g_stage
      localparam int SB = 1 << s;
      if (SB >= VBYTES) begin : g_clear
         assign stg[s+1] = amt[s] ? '0 : stg[s];
      end else if (TOWARD_HIGH) begin : g_up
         assign stg[s+1] = amt[s] ? {stg[s][W-1-SB*8:0], {(SB*8){1'b0}}} : stg[s];
      end else begin : g_down
         assign stg[s+1] = amt[s] ? {{(SB*8){1'b0}}, stg[s][W-1:SB*8]} : stg[s];
      end
   end

   assign dout = stg[AMTW];

endmodule

// File: rtl/vsplice_merge.sv
module vsplice_merge #(
   parameter  int VBYTES = 32,
   localparam int LENW   = $clog2(VBYTES + 1),
   localparam int W      = VBYTES * 8
) (
   input  logic [W-1:0]    seg,
   input  logic [W-1:0]    fill,
   input  logic [LENW-1:0] seg_len,
   output logic [W-1:0]    dout
);

   for (genvar i = 0; i < VBYTES; i++) begin : g_byte
      localparam logic [LENW-1:0] IL = LENW'(i);
      assign dout[i*8 +: 8] = (IL < seg_len) ? seg[i*8 +: 8] : fill[i*8 +: 8];
   end

endmodule

// File: rtl/vsplice_unit.sv
module vsplice_unit
   import vsplice_pkg::*;
#(
   parameter  int VBYTES = 32,
   localparam int W      = VBYTES * 8,
   localparam int IDXW   = $clog2(VBYTES),
   localparam int LENW   = $clog2(VBYTES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [1:0]        elem_size,
   input  logic [W-1:0]      vec_a,
   input  logic [W-1:0]      vec_b,
   input  logic [VBYTES-1:0] pred,
   output logic              out_valid,
   output logic [W-1:0]      out_vec
);

   if (VBYTES < 8 || (VBYTES % 8) != 0) begin : g_bad_width
      $error("vsplice_unit: VBYTES must be a multiple of 8 and at least 8");
   end

   logic            any_act;
   logic [IDXW-1:0] first_pos;
   logic [LENW-1:0] seg_len;
   logic [W-1:0]    a_down;
   logic [W-1:0]    b_up;
   logic [W-1:0]    merged;

   vsplice_span #(.VBYTES(VBYTES)) i_span (
      .clk       (clk),
      .rst_n     (rst_n),
      .pred      (pred),
      .esz       (esz_e'(elem_size)),
      .any_act   (any_act),
      .first_pos (first_pos),
      .seg_len   (seg_len)
   );

   vsplice_shift #(.VBYTES(VBYTES), .TOWARD_HIGH(1'b0)) i_shift_a (
      .din  (vec_a),
      .amt  (LENW'(first_pos)),
      .dout (a_down)
   );

   vsplice_shift #(.VBYTES(VBYTES), .TOWARD_HIGH(1'b1)) i_shift_b (
      .din  (vec_b),
      .amt  (seg_len),
      .dout (b_up)
   );

   vsplice_merge #(.VBYTES(VBYTES)) i_merge (
      .seg     (a_down),
      .fill    (b_up),
      .seg_len (seg_len),
      .dout    (merged)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_vec   <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) out_vec <= merged;
      end
   end

   // R7
   valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   // R7
   valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   // R8
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(out_vec));

   // R5
   empty_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !any_act) |=> (out_vec == $past(vec_b)));

   // R2
   head_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && any_act) |=> (out_vec[7:0] == $past(vec_a[{first_pos, 3'b000} +: 8])));

endmodule

// File: tb/test_vsplice_unit.sv
module test_vsplice_unit;

   localparam int CLK_PERIOD = 10;
   localparam int VB         = 32;
   localparam int W          = VB * 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [1:0]    elem_size = 2'd0;
   logic [W-1:0]  vec_a = '0;
   logic [W-1:0]  vec_b = '0;
   logic [VB-1:0] pred = '0;
   logic          out_valid;
   logic [W-1:0]  out_vec;

   int n_checks = 0;
   int n_fails  = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   vsplice_unit #(.VBYTES(VB)) i_vsplice_unit (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .elem_size (elem_size),
      .vec_a     (vec_a),
      .vec_b     (vec_b),
      .pred      (pred),
      .out_valid (out_valid),
      .out_vec   (out_vec)
   );

   function automatic logic [W-1:0] ref_splice(logic [W-1:0] a, logic [W-1:0] b,
                                               logic [VB-1:0] p, int esz);
      int eb = 1 << esz;
      int f  = -1;
      int l  = -1;
      int len;
      logic [W-1:0] r;
      for (int i = 0; i < VB; i++) begin
         if ((i % eb) == 0 && p[i]) begin
            if (f < 0) f = i;
            l = i;
         end
      end
      len = (f < 0) ? 0 : (l - f + eb);
      for (int i = 0; i < VB; i++) begin
         if (i < len) r[i*8 +: 8] = a[(f + i)*8 +: 8];
         else         r[i*8 +: 8] = b[(i - len)*8 +: 8];
      end
      return r;
   endfunction

   function automatic logic [W-1:0] rnd_vec();
      logic [W-1:0] v;
      for (int i = 0; i < W / 32; i++) v[i*32 +: 32] = $urandom;
      return v;
   endfunction

   task automatic chk(bit ok, string req, logic [W-1:0] act, logic [W-1:0] exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // one strobe, then check the result cycle and the following idle cycle
   task automatic apply(logic [W-1:0] a, logic [W-1:0] b, logic [VB-1:0] p,
                        int esz, string req);
      logic [W-1:0] exp = ref_splice(a, b, p, esz);
      @(negedge clk);
      in_valid = 1'b1; vec_a = a; vec_b = b; pred = p; elem_size = 2'(esz);
      @(negedge clk);
      in_valid = 1'b0; vec_a = rnd_vec(); vec_b = rnd_vec(); pred = $urandom;
      chk(out_valid === 1'b1, "R7 valid", W'(out_valid), W'(1));
      chk(out_vec === exp, req, out_vec, exp);
      @(negedge clk);
      chk(out_valid === 1'b0, "R7 single pulse", W'(out_valid), W'(0));
      chk(out_vec === exp, "R8 hold", out_vec, exp);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   end

   initial begin : stim
      logic [W-1:0] a, b, a2, b2, e1, e2;
      logic [VB-1:0] p, p2;
      void'($urandom(32'd20240611));

      repeat (3) @(negedge clk);
      // R9 reset state
      chk(out_valid === 1'b0, "R9 reset valid", W'(out_valid), W'(0));
      chk(out_vec === '0, "R9 reset data", out_vec, '0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(out_valid === 1'b0, "R9 idle after reset", W'(out_valid), W'(0));

      // R6 all active, each element size
      for (int e = 0; e < 4; e++) begin
         a = rnd_vec(); b = rnd_vec();
         apply(a, b, '1, e, "R6 all active");
         chk(out_vec === a, "R6 equals vec_a", out_vec, a);
      end

      // R5 nothing active
      a = rnd_vec(); b = rnd_vec();
      apply(a, b, '0, 0, "R5 none active");
      chk(out_vec === b, "R5 equals vec_b", out_vec, b);

      // R1 only misaligned bits set for 8-byte elements -> behaves as none active
      a = rnd_vec(); b = rnd_vec();
      apply(a, b, 32'h7E7E_7E7E, 3, "R1 misaligned ignored");
      chk(out_vec === b, "R1 misaligned gives vec_b", out_vec, b);

      // R2 R4 single active 4-byte element at byte 8: segment of 4 bytes
      a = rnd_vec(); b = rnd_vec();
      apply(a, b, 32'h0000_0100, 2, "R2 single active");
      chk(out_vec[31:0] === a[95:64], "R2 segment bytes", W'(out_vec[31:0]), W'(a[95:64]));
      chk(out_vec[W-1:32] === b[W-33:0], "R4 back-fill", W'(out_vec[W-1:32]), W'(b[W-33:0]));

      // R3 first and last only (bytes 4 and 20, 4-byte elements): inactive middle kept
      a = rnd_vec(); b = rnd_vec();
      apply(a, b, 32'h0010_0010, 2, "R3 first and last");
      chk(out_vec[159:0] === a[191:32], "R3 inactive middle copied",
          W'(out_vec[159:0]), W'(a[191:32]));
      chk(out_vec[W-1:160] === b[95:0], "R4 fill after span",
          W'(out_vec[W-1:160]), W'(b[95:0]));

      // R2 last element at the very top, 2-byte elements
      a = rnd_vec(); b = rnd_vec();
      apply(a, b, 32'h4000_0004, 1, "R2 span to top");

      // R7 back-to-back strobes
      a = rnd_vec(); b = rnd_vec(); p = $urandom;
      a2 = rnd_vec(); b2 = rnd_vec(); p2 = $urandom;
      e1 = ref_splice(a, b, p, 0);
      e2 = ref_splice(a2, b2, p2, 2);
      @(negedge clk);
      in_valid = 1'b1; vec_a = a; vec_b = b; pred = p; elem_size = 2'd0;
      @(negedge clk);
      vec_a = a2; vec_b = b2; pred = p2; elem_size = 2'd2;
      chk(out_valid === 1'b1, "R7 back-to-back first", W'(out_valid), W'(1));
      chk(out_vec === e1, "R7 back-to-back first data", out_vec, e1);
      @(negedge clk);
      in_valid = 1'b0;
      chk(out_valid === 1'b1, "R7 back-to-back second", W'(out_valid), W'(1));
      chk(out_vec === e2, "R7 back-to-back second data", out_vec, e2);
      @(negedge clk);
      chk(out_valid === 1'b0, "R7 back-to-back end", W'(out_valid), W'(0));

      // R2 R3 R4 random predicates, all element sizes, dense and sparse
      for (int e = 0; e < 4; e++) begin
         for (int n = 0; n < 60; n++) begin
            a = rnd_vec(); b = rnd_vec();
            p = $urandom;
            if (n % 3 == 1) p = p & $urandom & $urandom;
            if (n % 3 == 2) p = p & $urandom & $urandom & $urandom & $urandom;
            apply(a, b, p, e, "R2 R4 random splice");
         end
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   end

endmodule